// File: doc/BRIEF.md
# Scan-Skip Sample Decimator

This block sits after an acquisition FIFO on a board with a single conversion timer. It lets software ask for a slow scan rate. The converter runs continuously at the conversion rate. The stream is split into chunks of N × (1 + D) samples, where N is the number of channels in one scan and D is the number of whole scans to skip. The first N samples of every chunk (one complete scan) are forwarded. The remaining N × D samples are consumed and discarded. With D = 0 the block is a transparent pass-through.

Software picks the skip count D so that the scan period equals (D + 1) × N × conversion period. For that reason the scan period must be a whole multiple of N conversion periods. The block only receives N and D. A one-cycle start pulse samples both values and rewinds the chunk position, so the first sample after the pulse is channel 0 of a kept scan.

Downstream back-pressure applies only to kept samples. Discarded samples are always accepted, so the position keeps moving through the dropped part of the chunk even while the output is stalled.

Top module: `scan_skip_decimator`

## Requirements
- R1: A kept sample is presented on the output in the same cycle it is offered: out_valid is high and out_data equals in_data.
- R2: The chunk length is N × (1 + D). Input samples at positions 0 to N−1 of a chunk are kept. Samples at positions N to N × (1 + D) − 1 are dropped and never raise out_valid.
- R3: After the sample at position N × (1 + D) − 1 is accepted, the position returns to 0, and the next sample is again kept as channel 0.
- R4: When D is 0, every accepted input sample is forwarded.
- R5: A dropped sample is accepted (in_ready high) whatever the level of out_ready, and it advances the position.
- R6: While a kept sample is offered and out_ready is low, in_ready is low and the position does not advance.
- R7: In a cycle with start high, N and D are sampled from cfg_scan_len and cfg_skip and the position is cleared. In that cycle in_ready and out_valid are both low. A cfg_scan_len of 0 is treated as 1.
- R8: After reset the block acts as if started with N = 1 and D = 0 (pass-through), with the position at 0.
- R9: Changes on cfg_scan_len or cfg_skip without a start pulse have no effect on which samples are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Acquisition start pulse: samples the configuration and clears the position |
| cfg_scan_len | input | LEN_W | Channels per scan N (0 treated as 1) |
| cfg_skip | input | SKIP_W | Number of whole scans to drop after each kept scan, D |
| in_valid | input | 1 | Input sample present |
| in_data | input | DATA_W | Input sample |
| in_ready | output | 1 | Input sample accepted this cycle when in_valid is high |
| out_valid | output | 1 | Kept sample present on out_data |
| out_data | output | DATA_W | Kept sample |
| out_ready | input | 1 | Downstream can take the sample |

## Verification
A position counter that is off by one shifts the kept window. It shows on the very next chunk as a channel-0 sample that is dropped, or as a dropped sample that raises out_valid. A wrong chunk length first becomes visible at the wrap, which is at most N × (1 + D) accepted samples after a start pulse. A counter that advances while a kept sample is stalled drops that sample silently, and this shows as in_ready high with out_ready low in the same cycle. The bench follows the position with its own model on every accepted sample and compares in_ready, out_valid and out_data each cycle, so any of these faults is reported within one chunk.

// File: rtl/scan_skip_decimator.sv
module scan_skip_decimator #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 6,
  parameter int SKIP_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  cfg_scan_len,
  input  logic [SKIP_W-1:0] cfg_skip,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready
);
  localparam int CNT_W = LEN_W + SKIP_W + 1;

  logic [CNT_W-1:0] scan_q, chunk_q, pos_q;

  wire [CNT_W-1:0] scan_eff  = (cfg_scan_len == '0) ? CNT_W'(1) : CNT_W'(cfg_scan_len);
  wire [CNT_W-1:0] chunk_new = scan_eff * (CNT_W'(cfg_skip) + CNT_W'(1));

  wire keep = pos_q < scan_q;
  wire wrap = pos_q == chunk_q - CNT_W'(1);

  assign in_ready  = !start && (keep ? out_ready : 1'b1);
  assign out_valid = !start && in_valid && keep;
  assign out_data  = in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_q  <= CNT_W'(1);
      chunk_q <= CNT_W'(1);
      pos_q   <= '0;
    end else if (start) begin
      scan_q  <= scan_eff;
      chunk_q <= chunk_new;
      pos_q   <= '0;
    end else if (in_valid && in_ready) begin
      pos_q <= wrap ? '0 : pos_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/scan_skip_decimator_chk.sv
module scan_skip_decimator_chk #(
  parameter int CNT_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [CNT_W-1:0] scan_q,
  input logic [CNT_W-1:0] chunk_q,
  input logic [CNT_W-1:0] pos_q
);
  a_r2_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q >= scan_q) |-> !out_valid);

  a_r3_pos_in_chunk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q < chunk_q);

  a_r4_no_skip_all_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_q == scan_q && !start) |-> (in_ready == out_ready));

  a_r5_drop_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && in_valid && pos_q >= scan_q && pos_q + 1 < chunk_q) |=> pos_q == $past(pos_q) + 1);

  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && in_valid && pos_q < scan_q && !out_ready) |=> $stable(pos_q));

  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> pos_q == '0);

  a_r1_valid_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_valid && in_ready == out_ready));
endmodule

bind scan_skip_decimator scan_skip_decimator_chk #(.CNT_W(LEN_W + SKIP_W + 1)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .scan_q(scan_q), .chunk_q(chunk_q), .pos_q(pos_q)
);

// File: tb/scan_skip_decimator_tb.sv
module scan_skip_decimator_tb_top;
  localparam int DATA_W = 16;
  localparam int LEN_W  = 6;
  localparam int SKIP_W = 6;

  logic clk = 0, rst_n = 0, start = 0;
  logic [LEN_W-1:0]  cfg_scan_len = '0;
  logic [SKIP_W-1:0] cfg_skip = '0;
  logic in_valid = 0, out_ready = 0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [DATA_W-1:0] out_data;

  int total = 0, bad = 0;
  int m_n = 1, m_chunk = 1, m_pos = 0;
  bit wrapped = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  scan_skip_decimator #(.DATA_W(DATA_W), .LEN_W(LEN_W), .SKIP_W(SKIP_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_scan_len(cfg_scan_len), .cfg_skip(cfg_skip),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  function automatic int eff_n(int n);
    return (n == 0) ? 1 : n;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare combinational outputs, advance model.
  task automatic cycle(bit st, int n, int d, bit v, bit rdy, string tag);
    bit keep, exp_rdy, exp_ov;
    string req;
    @(negedge clk);
    start = st; cfg_scan_len = LEN_W'(n); cfg_skip = SKIP_W'(d);
    in_valid = v; out_ready = rdy; in_data = DATA_W'($urandom);
    #1;
    keep    = m_pos < m_n;
    exp_rdy = !st && (keep ? rdy : 1'b1);
    exp_ov  = !st && v && keep;
    if (tag != "")                   req = tag;
    else if (st)                     req = "R7";
    else if (m_chunk == m_n)         req = "R4";
    else if (keep && !rdy)           req = "R6";
    else if (!keep)                  req = "R5";
    else if (wrapped && m_pos == 0)  req = "R3";
    else                             req = "R2";
    check(req, "in_ready", in_ready, exp_rdy);
    check(req, "out_valid", out_valid, exp_ov);
    if (exp_ov) check("R1", "out_data", out_data, in_data);
    if (st) begin
      m_n = eff_n(n); m_chunk = m_n * (d + 1); m_pos = 0; wrapped = 0;
    end else if (v && exp_rdy) begin
      if (m_pos == m_chunk - 1) begin m_pos = 0; wrapped = 1; end
      else begin m_pos++; wrapped = 0; end
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8: reset state is pass-through
    for (int i = 0; i < 6; i++) cycle(0, 0, 0, 1, 1, "R8");
    // R2/R3: N=3, D=2, steady stream
    cycle(1, 3, 2, 0, 1, "");
    for (int i = 0; i < 40; i++) cycle(0, 3, 2, 1, 1, "");
    // R6 then R5: stall kept and dropped samples
    cycle(1, 2, 3, 0, 1, "");
    for (int i = 0; i < 30; i++) cycle(0, 2, 3, 1, 0, "");
    for (int i = 0; i < 30; i++) cycle(0, 2, 3, 1, i % 3 != 0, "");
    // R4: D = 0
    cycle(1, 5, 0, 0, 1, "");
    for (int i = 0; i < 30; i++) cycle(0, 5, 0, 1, 1, "R4");
    // R7: N = 0 treated as 1
    cycle(1, 0, 4, 0, 1, "R7");
    for (int i = 0; i < 25; i++) cycle(0, 0, 4, 1, 1, "");
    // R9: wander config without start
    cycle(1, 4, 1, 0, 1, "");
    for (int i = 0; i < 40; i++) cycle(0, $urandom_range(0, 63), $urandom_range(0, 63), 1, 1, "R9");
    // Random mix
    for (int i = 0; i < 20000; i++) begin
      bit st = ($urandom_range(0, 299) == 0);
      cycle(st, $urandom_range(0, 9), $urandom_range(0, 5),
            $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0, "");
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule